// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one translation entry from a flat table in memory. A CPU-side client presents a request with a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. The walker forms the entry's address from a base register and the virtual page number. It issues one read on a ready/valid memory port and waits for the entry to come back. It then checks the entry's present bit and permission bits. It answers with either a physical address or a fault code.

The walker handles one request at a time and stays busy until it has answered. The base register can be rewritten at any time. A walk that is already in progress keeps the base value it captured when it accepted its request. The walker only reports faults. Fault handling belongs to the client.

Entry layout (32-bit entry, 4 bytes, default 1 KB pages): bit 0 present, bit 1 readable, bit 2 writable, bit 3 executable, bit 4 user-accessible. The frame number sits in the top `PA_W-PAGE_BITS` bits (bits 31:10 by default).

Top module: `pt_walker`

## Requirements
- R1: The read address driven on `mem_rd_addr` equals the base register value plus four times the virtual page number (`vaddr[VA_W-1:PAGE_BITS]`), wrapped to `PA_W` bits.
- R2: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is seen. Exactly one read is issued per accepted request, and `mem_rd_valid` is low once that read has been accepted.
- R3: A response with fault code 2'b00 carries `rsp_paddr` = {entry bits 31:10, `vaddr[9:0]`}. The page offset passes through unchanged.
- R4: An entry whose bit 0 is 0 gives fault code 2'b01, and `rsp_paddr` is zero.
- R5: Access kind 2'b00 (read) needs bit 1, 2'b01 (write) needs bit 2 and 2'b10 (fetch) needs bit 3. Kind 2'b11 is never permitted. A present entry lacking the needed bit gives fault code 2'b10 with `rsp_paddr` zero.
- R6: With `req_user`=1 a present entry also needs bit 4, else fault 2'b10. With `req_user`=0, bit 4 has no effect.
- R7: When an entry is both not present and lacks permission, the code is 2'b01.
- R8: `req_ready` is high only when idle. Requests presented while busy are not accepted and cause no further memory read.
- R9: A base register write during a walk does not change that walk's read address. The next request uses the new value.
- R10: During and after reset, `req_ready`=1, `rsp_valid`=0 and `mem_rd_valid`=0.
- R11: `rsp_valid` is a single-cycle pulse, given exactly once per accepted request, and never with fault code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | PA_W | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 permission |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |

## Verification
The bench targets entries that are both absent and under-privileged. A walker with the wrong fault priority would report a permission fault there. It rewrites the base register in the middle of a walk, which a walker reading the live base would fetch from the wrong entry. It also holds a request high while the walker is busy, which a walker that ignored its busy state would answer with a second memory read. Kernel access to entries without the user bit, the reserved access kind, wrap-around of the entry address, and memory stalls of several cycles on both the address and data phases are also covered. Mistakes in these cases show up as a wrong fault code, a leaked frame number or a dropped address.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the page table walker.
// Assumes a 32-bit entry with control bits in the low five positions.
package ptw_pkg;
    localparam int PTE_W = 32;

    // Entry bit positions
    localparam int PTE_PRESENT = 0;
    localparam int PTE_RD      = 1;
    localparam int PTE_WR      = 2;
    localparam int PTE_EX      = 3;
    localparam int PTE_USR     = 4;

    // Access kinds
    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_FETCH = 2'b10;

    // Fault codes
    localparam logic [1:0] FLT_NONE    = 2'b00;
    localparam logic [1:0] FLT_ABSENT  = 2'b01;
    localparam logic [1:0] FLT_PERMIT  = 2'b10;

    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_READ  = 3'd1,
        WS_WAIT  = 3'd2,
        WS_CHECK = 3'd3,
        WS_RESP  = 3'd4
    } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
// Entry address generator: base + (vpn << ENTRY_SHIFT), wrapped to PA_W.
// Assumes entries are 2**ENTRY_SHIFT bytes; purely combinational.
module ptw_addr_gen #(
    parameter int PA_W        = 32,
    parameter int VPN_W       = 22,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int SUM_W = PA_W + VPN_W + ENTRY_SHIFT;

    logic [SUM_W-1:0] base_ext;
    logic [SUM_W-1:0] idx_ext;
    logic [SUM_W-1:0] sum;

    // Widen both terms, add, keep the low PA_W bits
    always_comb begin
        base_ext   = {{(VPN_W+ENTRY_SHIFT){1'b0}}, base};
        idx_ext    = {{PA_W{1'b0}}, vpn, {ENTRY_SHIFT{1'b0}}};
        sum        = base_ext + idx_ext;
        entry_addr = sum[PA_W-1:0];
    end
endmodule

// File: rtl/ptw_perm_check.sv
// Entry checker: decides the fault code for one fetched entry.
// Absence wins over any permission problem; user mode also needs the user bit.
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int ENT_W = PTE_W
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [1:0]       acc,
    input  logic             user,
    output logic [1:0]       fault
);
    logic kind_ok;
    logic priv_ok;

    // Does the entry grant the requested kind of access
    always_comb begin
        unique case (acc)
            ACC_READ:  kind_ok = entry[PTE_RD];
            ACC_WRITE: kind_ok = entry[PTE_WR];
            ACC_FETCH: kind_ok = entry[PTE_EX];
            default:   kind_ok = 1'b0;
        endcase
    end

    // Privilege gate: kernel passes, user needs the user bit
    always_comb priv_ok = !user || entry[PTE_USR];

    // Combine with absence taking priority
    always_comb begin
        if (!entry[PTE_PRESENT])       fault = FLT_ABSENT;
        else if (!(kind_ok && priv_ok)) fault = FLT_PERMIT;
        else                            fault = FLT_NONE;
    end
endmodule

// File: rtl/pt_walker.sv
// Single-level page table walker.
// Accepts one request, reads one entry, checks it, answers with a one-cycle pulse.
// Assumes the memory returns data at least one cycle after accepting the read,
// and the client takes the response in the cycle it is presented.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_we,
    input  logic [PA_W-1:0] base_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_acc,
    input  logic            req_user,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_fault,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [31:0]     mem_rsp_data
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;

    walk_state_e           state_q;
    logic [PA_W-1:0]       base_q;
    logic [PAGE_BITS-1:0]  off_q;
    logic [1:0]            acc_q;
    logic                  user_q;
    logic [PA_W-1:0]       ent_addr_q;
    logic [PTE_W-1:0]      ent_q;
    logic [PA_W-1:0]       paddr_q;
    logic [1:0]            fault_q;

    logic [PA_W-1:0]       ent_addr_d;
    logic [1:0]            fault_d;
    logic                  accept;

    always_comb accept = req_valid && (state_q == WS_IDLE);

    ptw_addr_gen #(.PA_W(PA_W), .VPN_W(VPN_W), .ENTRY_SHIFT(2)) i_addr (
        .base       (base_q),
        .vpn        (req_vaddr[VA_W-1:PAGE_BITS]),
        .entry_addr (ent_addr_d)
    );

    ptw_perm_check #(.ENT_W(PTE_W)) i_perm (
        .entry (ent_q),
        .acc   (acc_q),
        .user  (user_q),
        .fault (fault_d)
    );

    // Base register: written any time, sampled only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    // Walk sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            unique case (state_q)
                WS_IDLE:  if (accept)        state_q <= WS_READ;
                WS_READ:  if (mem_rd_ready)  state_q <= WS_WAIT;
                WS_WAIT:  if (mem_rsp_valid) state_q <= WS_CHECK;
                WS_CHECK:                    state_q <= WS_RESP;
                WS_RESP:                     state_q <= WS_IDLE;
                default:                     state_q <= WS_IDLE;
            endcase
        end
    end

    // Capture request fields and entry address on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q      <= '0;
            acc_q      <= '0;
            user_q     <= 1'b0;
            ent_addr_q <= '0;
        end else if (accept) begin
            off_q      <= req_vaddr[PAGE_BITS-1:0];
            acc_q      <= req_acc;
            user_q     <= req_user;
            ent_addr_q <= ent_addr_d;
        end
    end

    // Capture the returned entry
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ent_q <= '0;
        else if (state_q == WS_WAIT && mem_rsp_valid) ent_q <= mem_rsp_data;
    end

    // Build the response from the checked entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else if (state_q == WS_CHECK) begin
            fault_q <= fault_d;
            paddr_q <= (fault_d == FLT_NONE) ? {ent_q[PTE_W-1 -: PPN_W], off_q} : '0;
        end
    end

    // Output drive
    always_comb begin
        req_ready    = (state_q == WS_IDLE);
        mem_rd_valid = (state_q == WS_READ);
        mem_rd_addr  = ent_addr_q;
        rsp_valid    = (state_q == WS_RESP);
        rsp_paddr    = paddr_q;
        rsp_fault    = fault_q;
    end
endmodule

// File: rtl/ptw_checker.sv
// Protocol and result checker for pt_walker, attached by bind.
// Keeps its own copy of the base register and of accepted request fields.
module ptw_checker #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            base_we,
    input logic [PA_W-1:0] base_wdata,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr
);
    logic [PA_W-1:0]      base_m;
    logic [PA_W-1:0]      addr_m;
    logic [PAGE_BITS-1:0] off_m;

    // Shadow base register
    always_ff @(posedge clk) begin
        if (!rst_n)       base_m <= '0;
        else if (base_we) base_m <= base_wdata;
    end

    // Shadow of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_m <= '0;
            off_m  <= '0;
        end else if (req_valid && req_ready) begin
            addr_m <= base_m + (PA_W'(req_vaddr[VA_W-1:PAGE_BITS]) << 2);
            off_m  <= req_vaddr[PAGE_BITS-1:0];
        end
    end

    // R1
    entry_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr == addr_m);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R2
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 2'b00 |-> rsp_paddr[PAGE_BITS-1:0] == off_m);

    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == '0);

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || rsp_valid) |-> !req_ready);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !mem_rd_valid && req_ready);

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault != 2'b11);
endmodule

bind pt_walker ptw_checker #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_we      (base_we),
    .base_wdata   (base_wdata),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr)
);

// File: tb/test_pt_walker.sv
// Bench for pt_walker: directed corner cases followed by seeded random walks.
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int          checks = 0;
    int          failures = 0;
    logic [31:0] base_model = '0;

    always #10 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [31:0] e, input logic [1:0] acc,
                                              input logic user);
        logic kind;
        if (!e[0]) return 2'b01;
        case (acc)
            2'b00:   kind = e[1];
            2'b01:   kind = e[2];
            2'b10:   kind = e[3];
            default: kind = 1'b0;
        endcase
        if (!kind || (user && !e[4])) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_paddr(input logic [31:0] e, input logic [31:0] va,
                                               input logic [1:0] f);
        return (f == 2'b00) ? {e[31:10], va[9:0]} : 32'h0;
    endfunction

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_we = 1'b1;
        base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
        base_model = b;
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic user,
                        input logic [31:0] ent, input int stall, input int lat,
                        input bit mid_base, input logic [31:0] new_base,
                        input bit poke, input string tag);
        logic [31:0] ea;
        logic [1:0]  ef;
        logic [31:0] ep;
        logic [31:0] first_addr;
        int n;
        ea = base_model + {va[31:10], 2'b00};
        ef = exp_fault(ent, acc, user);
        ep = exp_paddr(ent, va, ef);
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = user;
        @(negedge clk);
        req_valid = poke;
        req_vaddr = ~va;
        req_acc = 2'b00;
        if (mid_base) begin
            base_we = 1'b1; base_wdata = new_base;
            @(negedge clk);
            base_we = 1'b0; base_model = new_base;
        end
        n = 0;
        while (!mem_rd_valid && n < 50) begin @(negedge clk); n++; end
        chk(mem_rd_valid == 1'b1, "R2", "read issued", 32'(mem_rd_valid), 32'd1);
        first_addr = mem_rd_addr;
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(mem_rd_valid && mem_rd_addr == first_addr, "R2", "read held in stall",
                mem_rd_addr, first_addr);
        end
        chk(mem_rd_addr == ea, mid_base ? "R9" : "R1", "entry address", mem_rd_addr, ea);
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        chk(mem_rd_valid == 1'b0, "R2", "read dropped after accept", 32'(mem_rd_valid), 32'd0);
        repeat (lat) @(negedge clk);
        req_valid = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = ent;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
        chk(rsp_valid == 1'b1, "R11", "response given", 32'(rsp_valid), 32'd1);
        chk(rsp_fault == ef, tag, "fault code", 32'(rsp_fault), 32'(ef));
        chk(rsp_paddr == ep, tag, "physical address", rsp_paddr, ep);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11", "response one cycle", 32'(rsp_valid), 32'd0);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                chk(mem_rd_valid == 1'b0, "R8", "no read from busy request",
                    32'(mem_rd_valid), 32'd0);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_valid == 1'b0, "R10",
            "idle outputs in reset", {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_valid == 1'b0, "R10",
            "idle outputs after reset", {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);

        set_base(32'h0010_0000);
        // Kernel read of a readable page
        walk(32'h0000_5ABC, 2'b00, 1'b0, 32'hABCD_E403, 0, 0, 1'b0, '0, 1'b0, "R3");
        // Absent entry with every right set
        walk(32'h1234_5678, 2'b00, 1'b0, 32'hFFFF_FC1E, 2, 1, 1'b0, '0, 1'b0, "R4");
        // Absent and lacking rights: absence wins
        walk(32'h0000_0400, 2'b01, 1'b1, 32'h1111_1402, 0, 0, 1'b0, '0, 1'b0, "R7");
        // Write on a read-only page
        walk(32'h0000_0800, 2'b01, 1'b0, 32'h2222_2403, 1, 0, 1'b0, '0, 1'b0, "R5");
        // Fetch needs the execute bit
        walk(32'h0000_0C00, 2'b10, 1'b0, 32'h3333_3407, 0, 2, 1'b0, '0, 1'b0, "R5");
        walk(32'h0000_0C10, 2'b10, 1'b0, 32'h3333_340B, 0, 0, 1'b0, '0, 1'b0, "R5");
        // Reserved access kind
        walk(32'h0000_1000, 2'b11, 1'b0, 32'h4444_441F, 0, 0, 1'b0, '0, 1'b0, "R5");
        // User without the user bit, then kernel on the same entry
        walk(32'h0000_1404, 2'b00, 1'b1, 32'h5555_540F, 0, 0, 1'b0, '0, 1'b0, "R6");
        walk(32'h0000_1404, 2'b00, 1'b0, 32'h5555_540F, 0, 0, 1'b0, '0, 1'b0, "R6");
        walk(32'h0000_1404, 2'b01, 1'b1, 32'h5555_5417, 0, 0, 1'b0, '0, 1'b0, "R6");
        // Base rewritten mid-walk; next walk uses the new base
        walk(32'h0000_2000, 2'b00, 1'b0, 32'h6666_6403, 3, 1, 1'b1, 32'h0080_0000, 1'b0, "R9");
        walk(32'h0000_2000, 2'b00, 1'b0, 32'h6666_6403, 0, 0, 1'b0, '0, 1'b0, "R9");
        // Request held while busy is ignored
        walk(32'h0000_3333, 2'b00, 1'b0, 32'h7777_7403, 2, 2, 1'b0, '0, 1'b1, "R8");
        // Entry address wraps past the top of the address space
        set_base(32'hFFFF_FFF0);
        walk(32'hFFFF_FFFF, 2'b00, 1'b0, 32'h8888_8C03, 0, 0, 1'b0, '0, 1'b0, "R1");

        for (int i = 0; i < 80; i++) begin
            logic [31:0] va;
            logic [31:0] ent;
            logic [1:0]  acc;
            if (i % 10 == 0) set_base($urandom);
            va  = $urandom;
            ent = $urandom;
            if ($urandom_range(0, 3) != 0) ent[0] = 1'b1;
            acc = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            walk(va, acc, 1'($urandom_range(0, 1)), ent, $urandom_range(0, 3),
                 $urandom_range(0, 3), ($urandom_range(0, 7) == 0), $urandom,
                 1'b0, "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule